// File: doc/BRIEF.md
# Flit Width Doubler Buffer

This block sits at a point in a packet merge tree where the link width doubles. It accepts narrow flits, each with an end-of-packet flag, on a ready/valid input. It pairs consecutive flits into words twice as wide and queues them. Output is held back until the queue holds a programmable number of words, normally half a packet. From then on the rest of the packet leaves at double width, so a packet spends half as many cycles on the output as it took on the input.

A packet that ends on an odd flit count closes with a padded word: the upper half is zero and a half-valid flag is raised. A queued end-of-packet releases the output even when the fill threshold has not been reached, so short packets never stall. The input is throttled only when the word queue is full.

Top module: `flit_aggregator`

## Requirements
- R1: `out_data` is `2*FLIT_W` bits wide; the earlier flit of a pair sits in bits `[FLIT_W-1:0]` and the later flit in bits `[2*FLIT_W-1:FLIT_W]`.
- R2: While the output is not mid-packet, `out_valid` stays low until the queue holds at least `THRESH` words or contains a word carrying end-of-packet.
- R3: `in_ready` is low exactly when the queue holds `DEPTH` words (after reset has been released).
- R4: `out_eop` is 1 on the word that carries a packet's final flit and 0 on every other word, giving exactly one marked word per packet.
- R5: A packet with an odd flit count ends with a word whose low half is the final flit, high half is zero and `out_half` is 1; every other word has `out_half` 0.
- R6: Once a packet's first word has left, its remaining words are offered as soon as they are queued, with no threshold wait.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_data`, `out_eop` and `out_half` unchanged.
- R8: During reset `out_valid` and `in_ready` are 0; `in_ready` reaches 1 within two clocks of reset release.
- R9: Words leave in the order their flits arrived, across packet boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input flit offered |
| in_ready | output | 1 | Input flit can be taken |
| in_data | input | FLIT_W | Input flit payload |
| in_eop | input | 1 | Flit is the last of its packet |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 2*FLIT_W | Output word payload |
| out_eop | output | 1 | Word carries the packet's last flit |
| out_half | output | 1 | Only the low half of the word is valid |

## Verification
A wrong pairing register shows at the ports as swapped or duplicated halves on the very next word pushed, at most one output word later than the flit that caused it. A wrong fill count or end-of-packet tally shows as `out_valid` rising one or more cycles early or late against the threshold rule, or as `in_ready` dropping with room left; the reference model compares both every clock, so the cycle of divergence is the cycle reported. A stuck streaming state shows as a mid-packet stall at the first word after the threshold word when the input is slow.

// File: rtl/flitagg_pkg.sv
package flitagg_pkg;

  // Side-band bits stored with every queued word: {eop, half}.
  localparam int AGG_SIDE_W = 2;

  // Output gate: waiting for enough data, or streaming a started packet.
  typedef enum logic {
    AGG_GATHER = 1'b0,
    AGG_STREAM = 1'b1
  } agg_mode_e;

endpackage

// File: rtl/flitagg_pairer.sv
module flitagg_pairer #(
  parameter int FLIT_W = 2,
  localparam int WORD_W = 2 * FLIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flit_fire,
  input  logic [FLIT_W-1:0] flit_data,
  input  logic              flit_eop,
  output logic              word_push,
  output logic [WORD_W-1:0] word_data,
  output logic              word_eop,
  output logic              word_half
);

  logic              pend_q, pend_d;
  logic [FLIT_W-1:0] low_q;
  logic              low_en;

  always_comb begin
    pend_d = pend_q;
    if (flit_fire) begin
      pend_d = !pend_q && !flit_eop;
    end
    low_en    = flit_fire && !pend_q;
    word_push = flit_fire && (pend_q || flit_eop);
    word_eop  = flit_eop;
    word_half = !pend_q;
    if (pend_q) begin
      word_data = {flit_data, low_q};
    end else begin
      word_data = {{FLIT_W{1'b0}}, flit_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (low_en) begin
      low_q <= flit_data;
    end
  end

endmodule

// File: rtl/flitagg_fifo.sv
module flitagg_fifo #(
  parameter int ENT_W = 6,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] push_ent,
  input  logic             push_eop,
  input  logic             pop,
  output logic [ENT_W-1:0] head_ent,
  output logic             head_eop,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] eop_cnt,
  output logic             full,
  output logic             empty
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic             eop_bit [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, eop_q, eop_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) begin
      return '0;
    end
    return p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
    eop_d = eop_q;
    case ({push && push_eop, pop && head_eop})
      2'b10:   eop_d = eop_q + CNT_W'(1);
      2'b01:   eop_d = eop_q - CNT_W'(1);
      default: eop_d = eop_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      eop_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      eop_q <= eop_d;
    end
  end

  // Storage: no reset, written only under the push enable.
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_q]     <= push_ent;
      eop_bit[wr_q] <= push_eop;
    end
  end

  assign head_ent = mem[rd_q];
  assign head_eop = eop_bit[rd_q];
  assign cnt      = cnt_q;
  assign eop_cnt  = eop_q;
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);

endmodule

// File: rtl/flitagg_gate.sv
module flitagg_gate
  import flitagg_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int THRESH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             empty,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] eop_cnt,
  input  logic             pop,
  input  logic             head_eop,
  output logic             release_word
);

  agg_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (pop) begin
      mode_d = head_eop ? AGG_GATHER : AGG_STREAM;
    end
    release_word = !empty &&
                   ((mode_q == AGG_STREAM) ||
                    (cnt >= CNT_W'(THRESH)) ||
                    (eop_cnt != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AGG_GATHER;
    end else begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/flit_aggregator.sv
module flit_aggregator
  import flitagg_pkg::*;
#(
  parameter int FLIT_W = 2,
  parameter int DEPTH  = 4,
  parameter int THRESH = 2,
  localparam int WORD_W = 2 * FLIT_W,
  localparam int ENT_W  = WORD_W + AGG_SIDE_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_eop,
  output logic              out_half
);

  logic             rs0_q, rst_sync_n;
  logic             flit_fire, word_push, word_eop, word_half;
  logic [WORD_W-1:0] word_data;
  logic [ENT_W-1:0] push_ent, head_ent;
  logic             head_eop, fifo_full, fifo_empty, pop;
  logic [CNT_W-1:0] word_cnt, eop_cnt;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs0_q      <= 1'b1;
      rst_sync_n <= rs0_q;
    end
  end

  assign in_ready  = rst_sync_n && !fifo_full;
  assign flit_fire = in_valid && in_ready;
  assign push_ent  = {word_eop, word_half, word_data};
  assign pop       = out_valid && out_ready;

  flitagg_pairer #(.FLIT_W(FLIT_W)) u_pair (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flit_fire (flit_fire),
    .flit_data (in_data),
    .flit_eop  (in_eop),
    .word_push (word_push),
    .word_data (word_data),
    .word_eop  (word_eop),
    .word_half (word_half)
  );

  flitagg_fifo #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (word_push),
    .push_ent (push_ent),
    .push_eop (word_eop),
    .pop      (pop),
    .head_ent (head_ent),
    .head_eop (head_eop),
    .cnt      (word_cnt),
    .eop_cnt  (eop_cnt),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  flitagg_gate #(.DEPTH(DEPTH), .THRESH(THRESH)) u_gate (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .empty        (fifo_empty),
    .cnt          (word_cnt),
    .eop_cnt      (eop_cnt),
    .pop          (pop),
    .head_eop     (head_eop),
    .release_word (out_valid)
  );

  assign out_data = head_ent[WORD_W-1:0];
  assign out_half = head_ent[WORD_W];
  assign out_eop  = head_ent[WORD_W+1];

endmodule

// File: rtl/flit_aggregator_chk.sv
module flit_aggregator_chk #(
  parameter int FLIT_W = 2,
  parameter int DEPTH  = 4,
  localparam int WORD_W = 2 * FLIT_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_eop,
  input logic              out_half,
  input logic [CNT_W-1:0]  word_cnt
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_eop) && $stable(out_half));

  p_half_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_half |-> out_eop && (out_data[WORD_W-1:FLIT_W] == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> word_cnt == CNT_W'(DEPTH));

  p_room_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt != CNT_W'(DEPTH) |-> in_ready);

  p_empty_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt == '0 |-> !out_valid);

endmodule

bind flit_aggregator flit_aggregator_chk #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_eop   (out_eop),
  .out_half  (out_half),
  .word_cnt  (word_cnt)
);

// File: tb/sim_flit_aggregator.sv
module sim_flit_aggregator;

  localparam int FW  = 2;
  localparam int DEP = 4;
  localparam int TH  = 2;
  localparam int WW  = 2 * FW;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 50000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, in_eop;
  logic [FW-1:0] in_data;
  logic          out_valid, out_ready, out_eop, out_half;
  logic [WW-1:0] out_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flit_aggregator #(.FLIT_W(FW), .DEPTH(DEP), .THRESH(TH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_eop(out_eop), .out_half(out_half)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit wd    = 0;

  // Reference state: flits to send {eop,data}; queued words {eop,half,data}.
  logic [FW:0]   fq [$];
  logic [WW+1:0] mq [$];
  bit            m_pend = 0;
  logic [FW-1:0] m_low  = '0;
  bit            m_go   = 0;
  int            vprob  = 100;
  int            rmode  = 0;
  bit            prev_hold = 0;
  logic [WW+1:0] prev_word = '0;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit eop_queued();
    foreach (mq[i]) if (mq[i][WW+1]) return 1;
    return 0;
  endfunction

  task automatic add_packet(input int len);
    for (int i = 0; i < len; i++) begin
      logic [FW-1:0] d = FW'($urandom);
      fq.push_back({(i == len - 1), d});
    end
  endtask

  task automatic step();
    bit exp_valid, exp_ready, acc, pop;
    logic [WW+1:0] w;
    logic [FW:0] f;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT && !wd) begin
      wd = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WD_LIMIT);
    end
    exp_valid = (mq.size() != 0) && (m_go || mq.size() >= TH || eop_queued());
    exp_ready = (mq.size() < DEP);
    chk(out_valid == exp_valid, "R2 R6 out_valid", out_valid, exp_valid);
    chk(in_ready == exp_ready, "R3 in_ready", in_ready, exp_ready);
    if (exp_valid && out_valid) begin
      w = mq[0];
      chk(out_data == w[WW-1:0], "R1 R9 out_data", out_data, w[WW-1:0]);
      chk(out_eop == w[WW+1], "R4 out_eop", out_eop, w[WW+1]);
      chk(out_half == w[WW], "R5 out_half", out_half, w[WW]);
    end
    if (prev_hold) begin
      chk(out_valid && {out_eop, out_half, out_data} == prev_word,
          "R7 hold", {out_valid, out_eop, out_half, out_data}, {1'b1, prev_word});
    end
    // drive inputs for this cycle
    in_valid = (fq.size() != 0) && (($urandom % 100) < vprob);
    if (fq.size() != 0) begin
      in_data = fq[0][FW-1:0];
      in_eop  = fq[0][FW];
    end else begin
      in_data = '0;
      in_eop  = 1'b0;
    end
    case (rmode)
      0:       out_ready = 1'b1;
      1:       out_ready = 1'b0;
      default: out_ready = ($urandom % 2) == 0;
    endcase
    // advance reference
    pop = exp_valid && out_ready;
    acc = in_valid && exp_ready;
    prev_hold = exp_valid && !out_ready;
    prev_word = {out_eop, out_half, out_data};
    if (pop) begin
      w = mq.pop_front();
      m_go = !w[WW+1];
    end
    if (acc) begin
      f = fq.pop_front();
      if (m_pend) begin
        mq.push_back({f[FW], 1'b0, f[FW-1:0], m_low});
        m_pend = 0;
      end else if (f[FW]) begin
        mq.push_back({1'b1, 1'b1, {FW{1'b0}}, f[FW-1:0]});
      end else begin
        m_pend = 1;
        m_low  = f[FW-1:0];
      end
    end
  endtask

  task automatic drain();
    while ((fq.size() != 0 || mq.size() != 0) && !wd) step();
    for (int i = 0; i < 3; i++) step();
  endtask

  initial begin
    void'($urandom(7));
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_data   = '0;
    in_eop    = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b0, "R8 in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R8 in_ready after release", in_ready, 1);
    chk(out_valid == 1'b0, "R8 out_valid after release", out_valid, 0);

    // Steady input, ready sink: threshold hold then stream (R2, R6)
    vprob = 100; rmode = 0;
    add_packet(6);
    add_packet(1);   // single flit: padded, eop releases below threshold (R5)
    add_packet(3);
    add_packet(2);
    drain();

    // Blocked sink fills the queue: backpressure and hold (R3, R7)
    rmode = 1;
    add_packet(12);
    add_packet(5);
    for (int i = 0; i < 30; i++) step();
    rmode = 0;
    drain();

    // Slow source: streaming must not re-wait on the threshold (R6)
    vprob = 30; rmode = 0;
    for (int i = 0; i < 10; i++) add_packet(1 + int'($urandom % 9));
    drain();

    // Mixed traffic, order across packets (R9)
    vprob = 70; rmode = 2;
    for (int i = 0; i < 60; i++) add_packet(1 + int'($urandom % 9));
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule